// File: doc/BRIEF.md
# Configuration Unlock Sequencer for a Pseudo-Static RAM

This block sits beside the command path of an asynchronous pseudo-static RAM model. It observes each individual read or write access and looks for a fixed six-access pattern aimed at the top address of the array. The pattern starts with a read. The next two writes send the data of that read back unchanged. Two further writes carry data that does not matter. A final read uses its address as a key that selects the new operating mode. When the pattern completes, the block loads a small configuration register that the burst and power-down logic elsewhere in the model consume.

Each access gives a one-cycle verdict in the cycle after its strobe. The verdict says whether a write goes through to the array or is suppressed, whether the returned read data must be treated as invalid, whether the access broke the rule that the device must return to standby between accesses, and whether a new configuration has just been applied. After the apply pulse the array contents are to be treated as undefined.

With the default parameters the address is 23 bits wide, so the top address is 7FFFFFh. Key bit 0 selects the read mode: 0 means asynchronous page read with normal write, 1 means synchronous burst. Key bits 2:1 select the power-down mode: 0 is sleep, 1 is partial retention, 2 is deep power-down, and 3 is not a legal choice.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset, cfgBurst is 0 (asynchronous) and cfgPwr is 0 (sleep), and wrPass, wrBlock, rdInvalid, protoErr and cfgApplied are all 0.
- R2: A complete legal sequence loads the configuration in the cycle after the access-6 strobe. The new values are cfgBurst = addr[0] and cfgPwr = addr[2:1] of access 6, and the other address bits have no effect. cfgApplied is high for exactly that one cycle, and the configuration does not change at any other time.
- R3: The access-6 read raises rdInvalid in the cycle after its strobe. No other read raises it.
- R4: If access 2 or 3 is a write to an address other than the top address, the sequence returns to idle, and that write is passed to the array (wrPass=1, wrBlock=0).
- R5: If access 4 or 5 is a write to an address other than the top address, the sequence returns to idle, and that write is suppressed (wrBlock=1, wrPass=0).
- R6: Write data at accesses 4 and 5 has no effect on the sequence. At accesses 2 and 3, write data that differs from the access-1 read data returns the sequence to idle, and the write passes.
- R7: Matching writes at accesses 2 and 3 pass to the array. Matching writes at accesses 4 and 5 are suppressed.
- R8: A read that breaks the pattern at accesses 2 to 5 returns the sequence to idle. If that read is itself a read of the top address, it is taken as a new access 1 and its data is captured.
- R9: An access that arrives with no standby cycle since the previous access raises protoErr in the next cycle and returns the sequence to idle. The access is then handled as an ordinary access: a write passes.
- R10: An access-6 key whose power-down field (addr[2:1]) is 3 leaves the configuration unchanged, gives no cfgApplied pulse, and returns the sequence to idle.
- R11: Outside a sequence, writes pass to the array and reads raise no flag. Every flag is 0 in any cycle that does not directly follow an access strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset (power-up) |
| rdStb | input | 1 | One-cycle strobe marking a read access |
| wrStb | input | 1 | One-cycle strobe marking a write access |
| standby | input | 1 | High while the device is idle between accesses |
| addr | input | AW | Access address |
| wrData | input | DW | Write data of a write access |
| rdData | input | DW | Data returned by the array for a read access |
| cfgBurst | output | 1 | Read mode: 0 asynchronous page, 1 synchronous burst |
| cfgPwr | output | 2 | Power-down mode: 0 sleep, 1 partial, 2 deep |
| wrPass | output | 1 | The previous write goes to the array |
| wrBlock | output | 1 | The previous write is suppressed |
| rdInvalid | output | 1 | The previous read returned invalid data |
| protoErr | output | 1 | The previous access came without an intervening standby |
| cfgApplied | output | 1 | One-cycle pulse: new configuration loaded |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle. They also rely on every flag being traced back to a strobe in the cycle before. The bench drives exactly one strobe per access, holds it for one cycle, and inserts a standby cycle after each access unless a case deliberately omits it to provoke a protocol error. It works on a 4-bit address and 4-bit data configuration. It sweeps every possible key address, every wrong address at each write step, and several captured data values.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WB1   = 3'd1,
    ST_WB2   = 3'd2,
    ST_DC1   = 3'd3,
    ST_DC2   = 3'd4,
    ST_KEY   = 3'd5
  } seqState_e;

  typedef struct packed {
    logic capRda;
    logic loadCfg;
    logic pass;
    logic block;
    logic rdInv;
    logic err;
  } ctlStrobe_t;

  localparam int KEY_BURST_BIT = 0;
  localparam int KEY_PWR_LSB   = 1;
  localparam int PWR_W         = 2;
  localparam logic [PWR_W-1:0] PWR_SLEEP   = 2'd0;
  localparam logic [PWR_W-1:0] PWR_ILLEGAL = 2'd3;

endpackage

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic       standby,
  input  logic       addrTop,
  input  logic       dataMatch,
  input  logic       keyLegal,
  output ctlStrobe_t strb
);

  seqState_e state, stateNext;
  logic      sawStandby;
  logic      anyAcc;

  assign anyAcc = rdStb | wrStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sawStandby <= 1'b1;
    end else if (anyAcc) begin
      sawStandby <= 1'b0;
    end else if (standby) begin
      sawStandby <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (anyAcc) begin
      if (!sawStandby) begin
        strb.err  = 1'b1;
        strb.pass = wrStb;
        stateNext = ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (rdStb && addrTop) begin
              strb.capRda = 1'b1;
              stateNext   = ST_WB1;
            end else begin
              strb.pass = wrStb;
            end
          end
          ST_WB1, ST_WB2: begin
            if (wrStb) begin
              strb.pass = 1'b1;
              if (addrTop && dataMatch)
                stateNext = (state == ST_WB1) ? ST_WB2 : ST_DC1;
              else
                stateNext = ST_IDLE;
            end else if (addrTop) begin
              strb.capRda = 1'b1;
              stateNext   = ST_WB1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
          ST_DC1, ST_DC2: begin
            if (wrStb) begin
              strb.block = 1'b1;
              if (addrTop)
                stateNext = (state == ST_DC1) ? ST_DC2 : ST_KEY;
              else
                stateNext = ST_IDLE;
            end else if (addrTop) begin
              strb.capRda = 1'b1;
              stateNext   = ST_WB1;
            end else begin
              stateNext = ST_IDLE;
            end
          end
          ST_KEY: begin
            if (rdStb) begin
              strb.rdInv   = 1'b1;
              strb.loadCfg = keyLegal;
            end else begin
              strb.pass = 1'b1;
            end
            stateNext = ST_IDLE;
          end
          default: stateNext = ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_unlock_dp.sv
module cfg_unlock_dp
  import cfg_unlock_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wrData,
  input  logic [DW-1:0]    rdData,
  output logic             addrTop,
  output logic             dataMatch,
  output logic             keyLegal,
  output logic             cfgBurst,
  output logic [PWR_W-1:0] cfgPwr,
  output logic             wrPass,
  output logic             wrBlock,
  output logic             rdInvalid,
  output logic             protoErr,
  output logic             cfgApplied
);

  localparam int PWR_MSB = KEY_PWR_LSB + PWR_W - 1;

  logic [DW-1:0]    rdaReg;
  logic [PWR_W-1:0] keyPwr;

  assign keyPwr    = addr[PWR_MSB:KEY_PWR_LSB];
  assign addrTop   = &addr;
  assign dataMatch = (wrData == rdaReg);
  assign keyLegal  = (keyPwr != PWR_ILLEGAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdaReg <= '0;
    end else if (strb.capRda) begin
      rdaReg <= rdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBurst <= 1'b0;
      cfgPwr   <= PWR_SLEEP;
    end else if (strb.loadCfg) begin
      cfgBurst <= addr[KEY_BURST_BIT];
      cfgPwr   <= keyPwr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPass     <= 1'b0;
      wrBlock    <= 1'b0;
      rdInvalid  <= 1'b0;
      protoErr   <= 1'b0;
      cfgApplied <= 1'b0;
    end else begin
      wrPass     <= strb.pass;
      wrBlock    <= strb.block;
      rdInvalid  <= strb.rdInv;
      protoErr   <= strb.err;
      cfgApplied <= strb.loadCfg;
    end
  end

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_unlock_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdStb,
  input  logic          wrStb,
  input  logic          standby,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] rdData,
  output logic          cfgBurst,
  output logic [1:0]    cfgPwr,
  output logic          wrPass,
  output logic          wrBlock,
  output logic          rdInvalid,
  output logic          protoErr,
  output logic          cfgApplied
);

  ctlStrobe_t strb;
  logic       addrTop;
  logic       dataMatch;
  logic       keyLegal;

  cfg_unlock_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdStb     (rdStb),
    .wrStb     (wrStb),
    .standby   (standby),
    .addrTop   (addrTop),
    .dataMatch (dataMatch),
    .keyLegal  (keyLegal),
    .strb      (strb)
  );

  cfg_unlock_dp #(.AW(AW), .DW(DW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .addrTop    (addrTop),
    .dataMatch  (dataMatch),
    .keyLegal   (keyLegal),
    .cfgBurst   (cfgBurst),
    .cfgPwr     (cfgPwr),
    .wrPass     (wrPass),
    .wrBlock    (wrBlock),
    .rdInvalid  (rdInvalid),
    .protoErr   (protoErr),
    .cfgApplied (cfgApplied)
  );

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdStb,
  input logic       wrStb,
  input logic       cfgBurst,
  input logic [1:0] cfgPwr,
  input logic       wrPass,
  input logic       wrBlock,
  input logic       rdInvalid,
  input logic       protoErr,
  input logic       cfgApplied
);

  a_in_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));

  a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    !cfgApplied |-> $stable({cfgBurst, cfgPwr}));

  a_r2_apply_after_key: assert property (@(posedge clk) disable iff (!rstN)
    cfgApplied |-> ($past(rdStb) && rdInvalid));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cfgApplied |=> !cfgApplied);

  a_r3_inv_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdInvalid |-> $past(rdStb));

  a_r5_pass_block_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPass && wrBlock));

  a_r7_wflags_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrPass || wrBlock) |-> $past(wrStb));

  a_r9_err_after_access: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(rdStb || wrStb));

  a_r10_pwr_legal: assert property (@(posedge clk) disable iff (!rstN)
    cfgPwr != 2'd3);

endmodule

bind cfg_unlock_seq cfg_unlock_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .rdStb      (rdStb),
  .wrStb      (wrStb),
  .cfgBurst   (cfgBurst),
  .cfgPwr     (cfgPwr),
  .wrPass     (wrPass),
  .wrBlock    (wrBlock),
  .rdInvalid  (rdInvalid),
  .protoErr   (protoErr),
  .cfgApplied (cfgApplied)
);

// File: tb/tb_cfg_unlock_seq.sv
`timescale 1ns/1ps
module tb_cfg_unlock_seq;

  localparam int AW  = 4;
  localparam int DW  = 4;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdStb = 1'b0;
  logic          wrStb = 1'b0;
  logic          standby = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData = '0;
  logic          cfgBurst;
  logic [1:0]    cfgPwr;
  logic          wrPass, wrBlock, rdInvalid, protoErr, cfgApplied;

  int nCmp = 0;
  int nBad = 0;
  int expBurst = 0;
  int expPwr = 0;

  always #2.5 clk = ~clk;

  cfg_unlock_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .wrStb(wrStb), .standby(standby),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .cfgBurst(cfgBurst), .cfgPwr(cfgPwr), .wrPass(wrPass), .wrBlock(wrBlock),
    .rdInvalid(rdInvalid), .protoErr(protoErr), .cfgApplied(cfgApplied)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chkCfg(string tag);
    chk(tag, "cfgBurst", int'(cfgBurst), expBurst);
    chk(tag, "cfgPwr", int'(cfgPwr), expPwr);
  endtask

  // one access; flags checked in the cycle after the strobe
  task automatic acc(bit w, int a, int d, bit gap,
                     int eP, int eB, int eI, int eE, int eA, string tag);
    @(negedge clk);
    standby = 1'b0;
    rdStb   = !w;
    wrStb   = w;
    addr    = AW'(a);
    wrData  = DW'(d);
    rdData  = DW'(d);
    @(negedge clk);
    rdStb = 1'b0;
    wrStb = 1'b0;
    chk(tag, "wrPass", int'(wrPass), eP);
    chk(tag, "wrBlock", int'(wrBlock), eB);
    chk(tag, "rdInvalid", int'(rdInvalid), eI);
    chk(tag, "protoErr", int'(protoErr), eE);
    chk(tag, "cfgApplied", int'(cfgApplied), eA);
    chkCfg(tag);
    if (gap) begin
      standby = 1'b1;
      @(negedge clk);
      standby = 1'b0;
      chk("R11 quiet", "flags", int'({wrPass, wrBlock, rdInvalid, protoErr, cfgApplied}), 0);
    end
  endtask

  // read of a non-top address: no flags when idle (shows the sequencer is idle)
  task automatic probeIdle(string tag);
    acc(0, 0, 0, 1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fullUnlock(int key, int rda);
    int legal;
    acc(0, TOP, rda, 1, 0, 0, 0, 0, 0, "R8 step1 read");
    acc(1, TOP, rda, 1, 1, 0, 0, 0, 0, "R7 step2 pass");
    acc(1, TOP, rda, 1, 1, 0, 0, 0, 0, "R7 step3 pass");
    acc(1, TOP, (~rda) & 15, 1, 0, 1, 0, 0, 0, "R6 step4 data ignored");
    acc(1, TOP, (rda + 5) & 15, 1, 0, 1, 0, 0, 0, "R7 step5 blocked");
    legal = (((key >> 1) & 3) != 3) ? 1 : 0;
    if (legal == 1) begin
      expBurst = key & 1;
      expPwr   = (key >> 1) & 3;
    end
    acc(0, key, 9, 1, 0, 0, 1, 0, legal, legal == 1 ? "R2 R3 key apply" : "R10 illegal key");
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", "flags", int'({wrPass, wrBlock, rdInvalid, protoErr, cfgApplied}), 0);
    chkCfg("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    chkCfg("R1 after release");

    // R11: ordinary traffic
    acc(1, 3, 7, 1, 1, 0, 0, 0, 0, "R11 idle write");
    acc(0, 5, 2, 1, 0, 0, 0, 0, 0, "R11 idle read");

    // R2 R3 R10: sweep every key address with several captured values
    for (int k = 0; k < 16; k++) fullUnlock(k, (k * 3 + 1) & 15);

    // R4: wrong address at access 2 or 3
    for (int st = 2; st <= 3; st++) begin
      for (int a = 0; a < TOP; a++) begin
        acc(0, TOP, a, 1, 0, 0, 0, 0, 0, "R4 step1");
        if (st == 3) acc(1, TOP, a, 1, 1, 0, 0, 0, 0, "R4 step2");
        acc(1, a, a, 1, 1, 0, 0, 0, 0, "R4 wrong addr passes");
        probeIdle("R4 back to idle");
      end
    end

    // R5: wrong address at access 4 or 5
    for (int st = 4; st <= 5; st++) begin
      for (int a = 0; a < TOP; a++) begin
        acc(0, TOP, 6, 1, 0, 0, 0, 0, 0, "R5 step1");
        acc(1, TOP, 6, 1, 1, 0, 0, 0, 0, "R5 step2");
        acc(1, TOP, 6, 1, 1, 0, 0, 0, 0, "R5 step3");
        if (st == 5) acc(1, TOP, 0, 1, 0, 1, 0, 0, 0, "R5 step4");
        acc(1, a, 1, 1, 0, 1, 0, 0, 0, "R5 wrong addr blocked");
        probeIdle("R5 back to idle");
      end
    end

    // R6: data mismatch at access 2 and at access 3
    for (int d = 0; d < 16; d++) begin
      if (d != 10) begin
        acc(0, TOP, 10, 1, 0, 0, 0, 0, 0, "R6 step1");
        acc(1, TOP, d, 1, 1, 0, 0, 0, 0, "R6 mismatch at step2 passes");
        probeIdle("R6 idle after mismatch");
        acc(0, TOP, 10, 1, 0, 0, 0, 0, 0, "R6 step1");
        acc(1, TOP, 10, 1, 1, 0, 0, 0, 0, "R6 step2");
        acc(1, TOP, d, 1, 1, 0, 0, 0, 0, "R6 mismatch at step3 passes");
        probeIdle("R6 idle after mismatch");
      end
    end

    // R8: non-top read at access 4 goes idle
    acc(0, TOP, 4, 1, 0, 0, 0, 0, 0, "R8 step1");
    acc(1, TOP, 4, 1, 1, 0, 0, 0, 0, "R8 step2");
    acc(1, TOP, 4, 1, 1, 0, 0, 0, 0, "R8 step3");
    acc(0, 7, 0, 1, 0, 0, 0, 0, 0, "R8 breaking read");
    probeIdle("R8 idle after break");

    // R8: top read at access 3 restarts with new captured data
    acc(0, TOP, 4, 1, 0, 0, 0, 0, 0, "R8 step1");
    acc(1, TOP, 4, 1, 1, 0, 0, 0, 0, "R8 step2");
    acc(0, TOP, 5, 1, 0, 0, 0, 0, 0, "R8 restart read");
    acc(1, TOP, 5, 1, 1, 0, 0, 0, 0, "R8 new step2");
    acc(1, TOP, 5, 1, 1, 0, 0, 0, 0, "R8 new step3");
    acc(1, TOP, 0, 1, 0, 1, 0, 0, 0, "R8 new step4");
    acc(1, TOP, 0, 1, 0, 1, 0, 0, 0, "R8 new step5");
    expBurst = 0; expPwr = 1;
    acc(0, 2, 0, 1, 0, 0, 1, 0, 1, "R8 restart applies");

    // R9: access without standby
    acc(0, TOP, 3, 0, 0, 0, 0, 0, 0, "R9 step1 no gap after");
    acc(1, TOP, 3, 1, 1, 0, 0, 1, 0, "R9 write flagged and passes");
    probeIdle("R9 idle after error");
    acc(0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 idle read no gap after");
    acc(0, TOP, 3, 1, 0, 0, 0, 1, 0, "R9 top read flagged");
    acc(1, TOP, 3, 1, 1, 0, 0, 0, 0, "R9 not taken as step1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule